// File: doc/BRIEF.md
# Compare-Match System Timer

This block is a system timer on a small register bus. It has a 32-bit up-counter that runs freely and one compare register. Software starts the counter from a programmed starting value. It can read the live count at any time. To schedule an event, it writes the current count plus a delta into the compare register. When the count reaches that value, a pending flag is latched. The interrupt line shows that flag while the compare interrupt is enabled.

The counter never reloads on a match. It rolls from 0xFFFFFFFF to zero and keeps going, so an event scheduled across the rollover still fires. The interrupt is acknowledged by reading the interrupt register, with no write needed. If a new match lands in the same cycle as that read, the match is kept.

Top module: `cmp_timer`

## Requirements
- R1: After reset every register reads zero, the counter is stopped and `irq` is low.
- R2: Writing 1 to bit 0 of the control register (offset 0x00) while the counter is stopped loads the starting-value register (offset 0x04) into the count on that clock edge.
- R3: While running, the count rises by one every clock and wraps from 0xFFFFFFFF to 0. Writing the starting-value register, or writing control bit 0 as 1 again, does not change the running count.
- R4: Writing 0 to control bit 0 stops the counter after the increment of that same edge. The count then holds its value.
- R5: The count register (offset 0x0C) reads the live count without disturbing it. Writes to that offset are ignored.
- R6: While running, a count equal to the compare register (offset 0x08) sets the pending flag on the next edge. The test is exact equality, so it also fires after a wrap.
- R7: `irq` is high exactly when the pending flag and the interrupt enable (bit 0 of offset 0x10) are both set. Clearing the enable drops `irq` but leaves the flag pending.
- R8: A read of offset 0x10 returns the enable in bit 0 and the pending flag in bit 8, with all other bits zero. The read clears the flag at the next edge.
- R9: When a match and a read of offset 0x10 occur in the same cycle, the flag ends up set.
- R10: The control, starting-value and compare registers read back what was last written. Control bit 0 is the only control bit stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | AW (5) | Byte offset of the register accessed |
| wdata | input | 32 | Write data |
| we | input | 1 | Write strobe, one cycle per write |
| re | input | 1 | Read strobe; marks a read with side effects |
| rdata | output | 32 | Combinational read data for `addr` |
| irq | output | 1 | Compare interrupt, level |

## Verification
The scheduling path is run from a table of starting values and deltas. A zero start with a mid-size delta shows plain counting. A delta of one exposes any off-by-one in the match timing. Starts just below 0xFFFFFFFF with matches at or past zero show whether equality survives the wrap. Each case checks that `irq` is still low one cycle before the expected match and high exactly on it. Directed cases then separate a stop from a hold, a reload from a running count, a disable from an acknowledge, and a lone read from a read that collides with a match.

// File: rtl/cmp_timer.sv
module cmp_timer #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  input  logic          we,
  input  logic          re,
  output logic [31:0]   rdata,
  output logic          irq
);
  localparam logic [AW-1:0] A_CTRL = AW'(5'h00);
  localparam logic [AW-1:0] A_LOAD = AW'(5'h04);
  localparam logic [AW-1:0] A_CMP  = AW'(5'h08);
  localparam logic [AW-1:0] A_CNT  = AW'(5'h0C);
  localparam logic [AW-1:0] A_IRQ  = AW'(5'h10);

  logic        en, irq_en, pend;
  logic [31:0] load_val, cmp_val, count;

  wire wr_ctrl = we && addr == A_CTRL;
  wire start   = wr_ctrl && wdata[0] && !en;
  wire hit     = en && count == cmp_val;
  wire ack     = re && addr == A_IRQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en       <= 1'b0;
      irq_en   <= 1'b0;
      pend     <= 1'b0;
      load_val <= '0;
      cmp_val  <= '0;
      count    <= '0;
    end else begin
      if (wr_ctrl)                en       <= wdata[0];
      if (we && addr == A_LOAD)   load_val <= wdata;
      if (we && addr == A_CMP)    cmp_val  <= wdata;
      if (we && addr == A_IRQ)    irq_en   <= wdata[0];
      if (start)                  count    <= load_val;
      else if (en)                count    <= count + 32'd1;
      if (hit)                    pend     <= 1'b1;
      else if (ack)               pend     <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = {31'd0, en};
      A_LOAD:  rdata = load_val;
      A_CMP:   rdata = cmp_val;
      A_CNT:   rdata = count;
      A_IRQ:   rdata = {23'd0, pend, 7'd0, irq_en};
      default: rdata = '0;
    endcase
  end

  assign irq = pend & irq_en;
endmodule

module cmp_timer_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic [31:0]   wdata,
  input logic          we,
  input logic          re,
  input logic          en,
  input logic          pend,
  input logic [31:0]   count,
  input logic [31:0]   cmp_val,
  input logic [31:0]   load_val
);
  assert_start_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(we && addr == AW'(5'h00) && wdata[0] && !en) |-> count == $past(load_val));

  assert_run_incr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en) |-> count == $past(count) + 32'd1);

  assert_stop_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(en) && !en) |-> $stable(count));

  assert_match_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en && count == cmp_val) |-> pend);

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(re && addr == AW'(5'h10) && !(en && count == cmp_val)) |-> !pend);
endmodule

bind cmp_timer cmp_timer_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we), .re(re),
  .en(en), .pend(pend), .count(count), .cmp_val(cmp_val), .load_val(load_val)
);

// File: tb/cmp_timer_bench.sv
`timescale 1ns/1ps
module cmp_timer_bench;
  localparam logic [4:0] A_CTRL = 5'h00, A_LOAD = 5'h04, A_CMP = 5'h08,
                         A_CNT = 5'h0C, A_IRQ = 5'h10;
  localparam int NV = 4;
  localparam logic [31:0] VLOAD  [NV] = '{32'h0000_0000, 32'h0000_0100, 32'hFFFF_FFFD, 32'hFFFF_FFFF};
  localparam int          VDELTA [NV] = '{5, 1, 6, 1};

  logic clk = 0, rst_n = 0, we = 0, re = 0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq;
  int errors = 0, checks = 0;
  bit done = 0;

  cmp_timer u_cmp_timer (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .we(we), .re(re), .rdata(rdata), .irq(irq));

  always #4 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] v);
    addr = a; re = 1; #1 v = rdata;
    @(negedge clk); re = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v, c;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    chk("R1 irq", {31'd0, irq}, 0);
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_LOAD, v); chk("R1 load", v, 0);
    rd(A_CMP, v);  chk("R1 cmp", v, 0);
    rd(A_CNT, v);  chk("R1 count", v, 0);
    rd(A_IRQ, v);  chk("R1 irqreg", v, 0);

    // table walk: R2 R6 R7 R8 and wrap
    for (int i = 0; i < NV; i++) begin
      wr(A_CTRL, 0);
      rd(A_IRQ, v);
      wr(A_LOAD, VLOAD[i]);
      wr(A_CMP, VLOAD[i] + 32'(VDELTA[i]));
      wr(A_IRQ, 1);
      wr(A_CTRL, 1);
      idle(VDELTA[i]);
      chk("R6 no early match", {31'd0, irq}, 0);
      idle(1);
      chk("R6 R7 match irq", {31'd0, irq}, 1);
      rd(A_CNT, v); chk("R2 R3 count after start", v, VLOAD[i] + 32'(VDELTA[i]) + 32'd1);
      rd(A_IRQ, v); chk("R8 irq read", v, 32'h101);
    end
    chk("R8 cleared by read", {31'd0, irq}, 0);

    // R3: load write while running leaves count alone
    rd(A_CNT, c); wr(A_LOAD, 32'h55); rd(A_CNT, v);
    chk("R3 load write running", v, c + 2);
    // R3: re-enable while running does not reload
    rd(A_CNT, c); wr(A_CTRL, 1); rd(A_CNT, v);
    chk("R3 re-enable running", v, c + 2);
    // R4: stop and hold
    rd(A_CNT, c); wr(A_CTRL, 0); rd(A_CNT, v);
    chk("R4 stop edge", v, c + 2);
    idle(5); rd(A_CNT, v);
    chk("R4 hold", v, c + 2);
    // R5: count write ignored
    wr(A_CNT, 32'h1234); rd(A_CNT, v);
    chk("R5 count write ignored", v, c + 2);

    // R7: disable keeps pending
    wr(A_LOAD, 10); wr(A_CMP, 12); wr(A_IRQ, 1); wr(A_CTRL, 1);
    idle(3);
    chk("R7 irq on match", {31'd0, irq}, 1);
    wr(A_IRQ, 0);
    chk("R7 irq off when disabled", {31'd0, irq}, 0);
    rd(A_IRQ, v); chk("R8 pending kept", v, 32'h100);
    rd(A_IRQ, v); chk("R8 pending cleared", v, 32'h000);

    // R9: match coincides with acknowledge read
    wr(A_CTRL, 0); wr(A_LOAD, 20); wr(A_CMP, 23); wr(A_IRQ, 1); wr(A_CTRL, 1);
    idle(3);
    rd(A_IRQ, v); chk("R9 read before set", v, 32'h001);
    chk("R9 match wins", {31'd0, irq}, 1);
    rd(A_IRQ, v); chk("R9 flag visible", v, 32'h101);
    chk("R9 then cleared", {31'd0, irq}, 0);

    // R10: readback
    rd(A_CTRL, v); chk("R10 ctrl", v, 1);
    wr(A_CTRL, 32'hFFFF_FFFF); rd(A_CTRL, v); chk("R10 ctrl bit0 only", v, 1);
    rd(A_LOAD, v); chk("R10 load", v, 20);
    rd(A_CMP, v);  chk("R10 cmp", v, 23);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule